// File: doc/BRIEF.md
# Four-by-four memory switch arbiter

This block lets four request-issuing masters reach any of four memory pseudo-channel ports that together make up a two-channel memory pair. The top bits of each request address choose the destination port. Every port has two arbiters, one for read requests and one for write requests. Each arbiter picks one master and lets it keep the port for a set number of short burst transactions. One master can be set up as the priority master. The other masters take turns in round-robin order.

On the way to a port, the block adds the index of the requesting master above the request ID. Read data and write responses that come back from the ports carry this widened ID. The block uses the added bits to send each response to the right master and removes them before delivery. All logic runs on one core clock. Each master's transaction budget (`TXN_COUNT`, 16 bits per master), the priority enable and the priority master are set by parameters. The request channels carry address and ID only; data paths are outside this block.

Top module: `mem_switch_arb`

## Requirements
- R1: A request whose top two address bits equal k is presented only at port k, with the full address forwarded unchanged.
- R2: The ID presented at a port is the 2-bit index of the granted master in the high bits, followed by that master's IW-bit request ID in the low bits.
- R3: For each port and direction, at most one master is presented at a time. A master sees ready only when its request is the one presented and the port is ready. While the port is stalled, no master sees ready.
- R4: Among masters other than the priority master, a port serves requesters in cyclic order. The next grant goes to the first requesting master after the last one granted. After reset the search starts at master 0.
- R5: A master holds a port for TXN_COUNT[16m+:16] accepted transactions as long as it keeps requesting. A value of 0 allows exactly one transaction. Other requesters at that port wait until the grant ends.
- R6: A master's budget counts its accepted transactions of one direction across all ports while it holds access. When the budget is used up at any port, the master loses its holds everywhere.
- R7: When enabled, the priority master is granted whenever it requests a port, even in the middle of another master's grant. Its grants leave the round-robin position unchanged.
- R8: If the grant holder stops requesting a port, the grant ends at once. The other requesters are arbitrated in the same cycle.
- R9: Read and write arbitration are independent. A write grant does not block or reorder reads at the same port, and a read grant does not affect writes.
- R10: A response with ID prefix m goes to master m with the prefix removed. The port's response ready follows master m's ready.
- R11: If several ports return responses to the same master in one cycle, the lowest-numbered port is delivered. The others see ready low.
- R12: With reset applied and all inputs idle, no port request is valid, no master sees ready, and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mArValid | input | 4 | Read request valid, one bit per master |
| mArReady | output | 4 | Read request accepted, per master |
| mArAddr | input | 4×AW | Read address per master |
| mArId | input | 4×IW | Read request ID per master |
| mAwValid | input | 4 | Write request valid per master |
| mAwReady | output | 4 | Write request accepted per master |
| mAwAddr | input | 4×AW | Write address per master |
| mAwId | input | 4×IW | Write request ID per master |
| sArValid | output | 4 | Read request valid per port |
| sArReady | input | 4 | Read request ready per port |
| sArAddr | output | 4×AW | Read address per port |
| sArId | output | 4×(IW+2) | Widened read ID per port |
| sAwValid | output | 4 | Write request valid per port |
| sAwReady | input | 4 | Write request ready per port |
| sAwAddr | output | 4×AW | Write address per port |
| sAwId | output | 4×(IW+2) | Widened write ID per port |
| sRValid | input | 4 | Read data valid per port |
| sRReady | output | 4 | Read data ready per port |
| sRId | input | 4×(IW+2) | Widened ID of read data per port |
| sRData | input | 4×DW | Read data per port |
| mRValid | output | 4 | Read data valid per master |
| mRReady | input | 4 | Read data ready per master |
| mRId | output | 4×IW | Read data ID per master |
| mRData | output | 4×DW | Read data per master |
| sBValid | input | 4 | Write response valid per port |
| sBReady | output | 4 | Write response ready per port |
| sBId | input | 4×(IW+2) | Widened ID of write response per port |
| mBValid | output | 4 | Write response valid per master |
| mBReady | input | 4 | Write response ready per master |
| mBId | output | 4×IW | Write response ID per master |

## Verification
The bench checks the exact order of grants when two or three masters compete with budgets of 0, 2 and 3. A design that counted one fewer or one more transaction, or that moved the round-robin pointer to the wrong master, would produce a different sequence. A master that moves to a second port after one transaction must lose access when its shared budget of two runs out there. A per-port counter would instead give it a second transaction at the new port. Other tests check priority preemption in the middle of a grant, early release when the holder stops requesting, and a stalled port that must not show ready to any master. On the response side, two ports return data to one master in the same cycle. A wrong priority here would deliver the wrong data or accept both responses.

// File: rtl/msw_pkg.sv
`timescale 1ns/1ps
package msw_pkg;
  localparam int NM = 4;            // masters
  localparam int NP = 4;            // pseudo-channel ports
  localparam int MW = $clog2(NM);   // master index width
  localparam int PW = $clog2(NP);   // port select width
  localparam int CW = 16;           // transaction count width

  // grant strobes for one direction
  typedef struct packed {
    logic [NP-1:0]         vld;
    logic [NP-1:0][MW-1:0] sel;
  } route_t;

  // control -> datapath: index 0 read, index 1 write
  typedef struct packed {
    route_t [1:0] dir;
  } strobe_t;
endpackage

// File: rtl/msw_arbiter.sv
`timescale 1ns/1ps
module msw_arbiter #(
  parameter int NM = 4,
  parameter bit PRIO_EN = 1'b0,
  parameter int PRIO_SEL = 0,
  localparam int MW = $clog2(NM)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NM-1:0] req,
  input  logic          portReady,
  input  logic [NM-1:0] relMask,
  output logic          grantVld,
  output logic [MW-1:0] grantIdx,
  output logic          accept,
  output logic          lockVld,
  output logic [MW-1:0] lockOwner
);
  logic [MW-1:0] rrPtr;
  logic          isPrio;

  always_comb begin
    grantVld = |req;
    grantIdx = '0;
    if (PRIO_EN && req[PRIO_SEL]) begin
      grantIdx = MW'(PRIO_SEL);
    end else if (lockVld && req[lockOwner]) begin
      grantIdx = lockOwner;
    end else begin
      for (int i = NM - 1; i >= 0; i--) begin
        if (req[rrPtr + MW'(i)]) grantIdx = rrPtr + MW'(i);
      end
    end
  end

  assign accept = grantVld && portReady;
  assign isPrio = PRIO_EN && (grantIdx == MW'(PRIO_SEL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockVld   <= 1'b0;
      lockOwner <= '0;
      rrPtr     <= '0;
    end else if (accept) begin
      lockVld   <= !relMask[grantIdx];
      lockOwner <= grantIdx;
      if (!isPrio) rrPtr <= grantIdx + MW'(1);
    end else if (lockVld && (!req[lockOwner] || relMask[lockOwner])) begin
      lockVld <= 1'b0;
    end
  end

  AST_LOCK_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockVld) |-> $past(accept)); // R5
endmodule

// File: rtl/msw_ctrl.sv
`timescale 1ns/1ps
module msw_ctrl import msw_pkg::*; #(
  parameter logic [NM*CW-1:0] TXN_COUNT = '0,
  parameter bit PRIO_EN = 1'b0,
  parameter int PRIO_SEL = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0][NP-1:0][NM-1:0] reqMat,
  input  logic [1:0][NP-1:0]         sReady,
  output strobe_t                    strobe
);
  wire logic [1:0][NP-1:0]         grantVld;
  wire logic [1:0][NP-1:0][MW-1:0] grantIdx;
  wire logic [1:0][NP-1:0]         accept;
  wire logic [1:0][NP-1:0]         lockVld;
  wire logic [1:0][NP-1:0][MW-1:0] lockOwner;
  logic [1:0][NM-1:0]              accM, holds, exhaust;
  logic [1:0][NM-1:0][CW-1:0]      used;
  logic [NM-1:0][CW-1:0]           lastIdx;

  for (genvar m = 0; m < NM; m++) begin : g_lim
    localparam logic [CW-1:0] LIM = TXN_COUNT[m*CW +: CW];
    assign lastIdx[m] = (LIM == '0) ? '0 : LIM - CW'(1);
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar p = 0; p < NP; p++) begin : g_port
      msw_arbiter #(.NM(NM), .PRIO_EN(PRIO_EN), .PRIO_SEL(PRIO_SEL)) u_arb (
        .clk(clk), .rstN(rstN), .req(reqMat[d][p]), .portReady(sReady[d][p]),
        .relMask(exhaust[d]), .grantVld(grantVld[d][p]), .grantIdx(grantIdx[d][p]),
        .accept(accept[d][p]), .lockVld(lockVld[d][p]), .lockOwner(lockOwner[d][p]));
    end
    for (genvar m = 0; m < NM; m++) begin : g_bud
      AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        used[d][m] <= lastIdx[m]); // R6
    end
  end

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      strobe.dir[d].vld = grantVld[d];
      strobe.dir[d].sel = grantIdx[d];
      for (int m = 0; m < NM; m++) begin
        accM[d][m]  = 1'b0;
        holds[d][m] = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (accept[d][p] && grantIdx[d][p] == MW'(m)) accM[d][m] = 1'b1;
          if (lockVld[d][p] && lockOwner[d][p] == MW'(m)) holds[d][m] = 1'b1;
        end
        exhaust[d][m] = accM[d][m] && (used[d][m] >= lastIdx[m]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      used <= '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        for (int m = 0; m < NM; m++) begin
          if (accM[d][m]) used[d][m] <= exhaust[d][m] ? '0 : used[d][m] + CW'(1);
          else if (!holds[d][m]) used[d][m] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/msw_path.sv
`timescale 1ns/1ps
module msw_path import msw_pkg::*; #(
  parameter int AW = 16,
  parameter int IW = 4,
  parameter int DW = 32,
  localparam int SIW = IW + MW
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0][NM-1:0]            mValid,
  input  logic [1:0][NM-1:0][AW-1:0]    mAddr,
  input  logic [1:0][NM-1:0][IW-1:0]    mId,
  output logic [1:0][NM-1:0]            mReady,
  output logic [1:0][NP-1:0]            sValid,
  output logic [1:0][NP-1:0][AW-1:0]    sAddr,
  output logic [1:0][NP-1:0][SIW-1:0]   sId,
  input  logic [1:0][NP-1:0]            sReady,
  output logic [1:0][NP-1:0][NM-1:0]    reqMat,
  input  strobe_t                       strobe,
  input  logic [NP-1:0]                 sRValid,
  output logic [NP-1:0]                 sRReady,
  input  logic [NP-1:0][SIW-1:0]        sRId,
  input  logic [NP-1:0][DW-1:0]         sRData,
  output logic [NM-1:0]                 mRValid,
  input  logic [NM-1:0]                 mRReady,
  output logic [NM-1:0][IW-1:0]         mRId,
  output logic [NM-1:0][DW-1:0]         mRData,
  input  logic [NP-1:0]                 sBValid,
  output logic [NP-1:0]                 sBReady,
  input  logic [NP-1:0][SIW-1:0]        sBId,
  output logic [NM-1:0]                 mBValid,
  input  logic [NM-1:0]                 mBReady,
  output logic [NM-1:0][IW-1:0]         mBId
);
  logic [1:0][NP-1:0][NM-1:0] readyAt;

  // request side: decode, mux, widen ID, return ready
  always_comb begin
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < NP; p++) begin
        for (int m = 0; m < NM; m++)
          reqMat[d][p][m] = mValid[d][m] && (mAddr[d][m][AW-1 -: PW] == PW'(p));
        sValid[d][p] = strobe.dir[d].vld[p];
        sAddr[d][p]  = mAddr[d][strobe.dir[d].sel[p]];
        sId[d][p]    = {strobe.dir[d].sel[p], mId[d][strobe.dir[d].sel[p]]};
      end
      for (int m = 0; m < NM; m++) begin
        mReady[d][m] = 1'b0;
        for (int p = 0; p < NP; p++) begin
          readyAt[d][p][m] = strobe.dir[d].vld[p] && sReady[d][p] &&
                             (strobe.dir[d].sel[p] == MW'(m));
          if (readyAt[d][p][m]) mReady[d][m] = 1'b1;
        end
      end
    end
  end

  // response side: route by ID prefix, lowest port wins a collision
  always_comb begin
    sRReady = '0;
    sBReady = '0;
    for (int m = 0; m < NM; m++) begin
      logic          hitR, hitB;
      logic [PW-1:0] pickR, pickB;
      hitR = 1'b0; hitB = 1'b0; pickR = '0; pickB = '0;
      for (int p = NP - 1; p >= 0; p--) begin
        if (sRValid[p] && sRId[p][SIW-1 -: MW] == MW'(m)) begin hitR = 1'b1; pickR = PW'(p); end
        if (sBValid[p] && sBId[p][SIW-1 -: MW] == MW'(m)) begin hitB = 1'b1; pickB = PW'(p); end
      end
      mRValid[m] = hitR;
      mRId[m]    = sRId[pickR][IW-1:0];
      mRData[m]  = sRData[pickR];
      if (hitR) sRReady[pickR] = mRReady[m];
      mBValid[m] = hitB;
      mBId[m]    = sBId[pickB][IW-1:0];
      if (hitB) sBReady[pickB] = mBReady[m];
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_chk
    for (genvar p = 0; p < NP; p++) begin : g_p
      AST_ONE_PER_PORT: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(readyAt[d][p])); // R3
      AST_ID_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
        sValid[d][p] |-> reqMat[d][p][sId[d][p][SIW-1 -: MW]]); // R2
    end
  end
  for (genvar p = 0; p < NP; p++) begin : g_rsp
    AST_RSP_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
      sRReady[p] |-> (sRValid[p] && mRReady[sRId[p][SIW-1 -: MW]])); // R10
  end
endmodule

// File: rtl/mem_switch_arb.sv
`timescale 1ns/1ps
module mem_switch_arb import msw_pkg::*; #(
  parameter int AW = 16,
  parameter int IW = 4,
  parameter int DW = 32,
  parameter logic [NM*CW-1:0] TXN_COUNT = '0,
  parameter bit PRIO_EN = 1'b0,
  parameter int PRIO_SEL = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NM-1:0]          mArValid,
  output logic [NM-1:0]          mArReady,
  input  logic [NM*AW-1:0]       mArAddr,
  input  logic [NM*IW-1:0]       mArId,
  input  logic [NM-1:0]          mAwValid,
  output logic [NM-1:0]          mAwReady,
  input  logic [NM*AW-1:0]       mAwAddr,
  input  logic [NM*IW-1:0]       mAwId,
  output logic [NP-1:0]          sArValid,
  input  logic [NP-1:0]          sArReady,
  output logic [NP*AW-1:0]       sArAddr,
  output logic [NP*(IW+MW)-1:0]  sArId,
  output logic [NP-1:0]          sAwValid,
  input  logic [NP-1:0]          sAwReady,
  output logic [NP*AW-1:0]       sAwAddr,
  output logic [NP*(IW+MW)-1:0]  sAwId,
  input  logic [NP-1:0]          sRValid,
  output logic [NP-1:0]          sRReady,
  input  logic [NP*(IW+MW)-1:0]  sRId,
  input  logic [NP*DW-1:0]       sRData,
  output logic [NM-1:0]          mRValid,
  input  logic [NM-1:0]          mRReady,
  output logic [NM*IW-1:0]       mRId,
  output logic [NM*DW-1:0]       mRData,
  input  logic [NP-1:0]          sBValid,
  output logic [NP-1:0]          sBReady,
  input  logic [NP*(IW+MW)-1:0]  sBId,
  output logic [NM-1:0]          mBValid,
  input  logic [NM-1:0]          mBReady,
  output logic [NM*IW-1:0]       mBId
);
  localparam int SIW = IW + MW;

  logic [1:0][NM-1:0]          mValid, mReady;
  logic [1:0][NM-1:0][AW-1:0]  mAddr;
  logic [1:0][NM-1:0][IW-1:0]  mId;
  logic [1:0][NP-1:0]          sValid, sReady;
  logic [1:0][NP-1:0][AW-1:0]  sAddr;
  logic [1:0][NP-1:0][SIW-1:0] sId;
  logic [1:0][NP-1:0][NM-1:0]  reqMat;
  strobe_t                     strobe;

  assign mValid = {mAwValid, mArValid};
  assign mAddr  = {mAwAddr, mArAddr};
  assign mId    = {mAwId, mArId};
  assign sReady = {sAwReady, sArReady};
  assign {mAwReady, mArReady} = mReady;
  assign {sAwValid, sArValid} = sValid;
  assign {sAwAddr, sArAddr}   = sAddr;
  assign {sAwId, sArId}       = sId;

  msw_ctrl #(.TXN_COUNT(TXN_COUNT), .PRIO_EN(PRIO_EN), .PRIO_SEL(PRIO_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqMat(reqMat), .sReady(sReady), .strobe(strobe));

  msw_path #(.AW(AW), .IW(IW), .DW(DW)) u_path (
    .clk(clk), .rstN(rstN), .mValid(mValid), .mAddr(mAddr), .mId(mId), .mReady(mReady),
    .sValid(sValid), .sAddr(sAddr), .sId(sId), .sReady(sReady), .reqMat(reqMat),
    .strobe(strobe), .sRValid(sRValid), .sRReady(sRReady), .sRId(sRId), .sRData(sRData),
    .mRValid(mRValid), .mRReady(mRReady), .mRId(mRId), .mRData(mRData),
    .sBValid(sBValid), .sBReady(sBReady), .sBId(sBId), .mBValid(mBValid),
    .mBReady(mBReady), .mBId(mBId));
endmodule

// File: tb/mem_switch_arb_tb.sv
`timescale 1ns/1ps
module mem_switch_arb_tb;
  // budgets: m0=2, m1=3, m2=0 (one), m3=1; master 3 has priority
  localparam logic [63:0] TXN = {16'd1, 16'd0, 16'd3, 16'd2};

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] mArValid, mArReady, mAwValid, mAwReady;
  logic [63:0] mArAddr, mAwAddr, sArAddr, sAwAddr;
  logic [15:0] mArId, mAwId, mRId, mBId;
  logic [3:0] sArValid, sArReady, sAwValid, sAwReady;
  logic [23:0] sArId, sAwId, sRId, sBId;
  logic [3:0] sRValid, sRReady, mRValid, mRReady;
  logic [3:0] sBValid, sBReady, mBValid, mBReady;
  logic [127:0] sRData, mRData;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_switch_arb #(.AW(16), .IW(4), .DW(32), .TXN_COUNT(TXN), .PRIO_EN(1'b1), .PRIO_SEL(3)) u_dut (
    .clk(clk), .rstN(rstN),
    .mArValid(mArValid), .mArReady(mArReady), .mArAddr(mArAddr), .mArId(mArId),
    .mAwValid(mAwValid), .mAwReady(mAwReady), .mAwAddr(mAwAddr), .mAwId(mAwId),
    .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr), .sArId(sArId),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwAddr(sAwAddr), .sAwId(sAwId),
    .sRValid(sRValid), .sRReady(sRReady), .sRId(sRId), .sRData(sRData),
    .mRValid(mRValid), .mRReady(mRReady), .mRId(mRId), .mRData(mRData),
    .sBValid(sBValid), .sBReady(sBReady), .sBId(sBId),
    .mBValid(mBValid), .mBReady(mBReady), .mBId(mBId));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    mArValid = '0; mAwValid = '0; mArAddr = '0; mAwAddr = '0; mArId = '0; mAwId = '0;
    sArReady = 4'hF; sAwReady = 4'hF; mRReady = 4'hF; mBReady = 4'hF;
    sRValid = '0; sBValid = '0; sRId = '0; sBId = '0; sRData = '0;
  endtask

  task automatic doReset();
    clearAll();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setAr(input int m, input int port, input logic [3:0] id);
    mArValid[m] = 1'b1;
    mArAddr[m*16 +: 16] = {port[1:0], 14'(m + 'h40)};
    mArId[m*4 +: 4] = id;
  endtask

  // run a fixed request set and compare the granted master each cycle
  task automatic runSeq(input string tag, input int n, input int seq[8]);
    for (int k = 0; k < n; k++) begin
      #1 chk(tag, 64'(mArReady), 64'(4'(1 << seq[k])));
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    clearAll();
    rstN = 1'b0;
    @(negedge clk);
    chk("R12 port valid in reset", 64'({sArValid, sAwValid}), 64'h0);
    chk("R12 master ready in reset", 64'({mArReady, mAwReady}), 64'h0);
    chk("R12 response valid in reset", 64'({mRValid, mBValid}), 64'h0);
    rstN = 1'b1;
  endtask

  task automatic tDecode();
    doReset();
    setAr(1, 2, 4'd5);
    #1;
    chk("R1 port select", 64'(sArValid), 64'h4);
    chk("R1 address forwarded", 64'(sArAddr[2*16 +: 16]), 64'({2'd2, 14'h41}));
    chk("R2 widened id", 64'(sArId[2*6 +: 6]), 64'({2'd1, 4'd5}));
    chk("R3 ready to requester", 64'(mArReady), 64'h2);
  endtask

  task automatic tStall();
    doReset();
    setAr(0, 0, 4'd1);
    setAr(1, 0, 4'd2);
    sArReady = 4'b1110;
    #1;
    chk("R3 stalled port no ready", 64'(mArReady), 64'h0);
    chk("R3 one presented", 64'(sArValid), 64'h1);
    chk("R3 presented owner", 64'(sArId[5:4]), 64'h0);
    sArReady = 4'hF;
    #1 chk("R3 ready after stall", 64'(mArReady), 64'h1);
  endtask

  task automatic tBudget();
    int s[8] = '{0, 0, 1, 1, 1, 0, 0, 1};
    doReset();
    setAr(0, 0, 4'd0);
    setAr(1, 0, 4'd0);
    runSeq("R5 budgets 2 and 3", 8, s);
  endtask

  task automatic tZeroCount();
    int s[8] = '{0, 0, 2, 0, 0, 2, 0, 0};
    doReset();
    setAr(0, 1, 4'd0);
    setAr(2, 1, 4'd0);
    runSeq("R5 zero count gives one", 6, s);
  endtask

  task automatic tRoundRobin();
    int s[8] = '{0, 0, 1, 1, 1, 2, 0, 0};
    doReset();
    setAr(0, 3, 4'd0);
    setAr(1, 3, 4'd0);
    setAr(2, 3, 4'd0);
    runSeq("R4 cyclic order", 8, s);
  endtask

  task automatic tPriority();
    doReset();
    setAr(0, 0, 4'd0);
    #1 chk("R7 first holder", 64'(mArReady), 64'h1);
    @(negedge clk);
    setAr(3, 0, 4'd0);
    #1 chk("R7 priority preempts", 64'(mArReady), 64'h8);
    @(negedge clk);
    mArValid[3] = 1'b0;
    #1 chk("R7 pointer kept", 64'(mArReady), 64'h1);
  endtask

  task automatic tCrossPort();
    doReset();
    setAr(0, 0, 4'd0);
    #1 chk("R6 first at port0", 64'(mArReady), 64'h1);
    @(negedge clk);
    setAr(0, 1, 4'd0);
    setAr(1, 1, 4'd0);
    #1 chk("R6 second at port1", 64'(mArReady), 64'h1);
    chk("R6 moved to port1", 64'(sArValid), 64'h2);
    @(negedge clk);
    #1 chk("R6 shared budget spent", 64'(mArReady), 64'h2);
  endtask

  task automatic tRelease();
    doReset();
    setAr(1, 2, 4'd0);
    #1 chk("R8 holder starts", 64'(mArReady), 64'h2);
    @(negedge clk);
    setAr(0, 2, 4'd0);
    #1 chk("R8 holder kept", 64'(mArReady), 64'h2);
    @(negedge clk);
    mArValid[1] = 1'b0;
    #1 chk("R8 released on drop", 64'(mArReady), 64'h1);
  endtask

  task automatic tIndep();
    doReset();
    setAr(1, 0, 4'd7);
    mAwValid[0] = 1'b1;
    mAwAddr[15:0] = {2'd0, 14'h3};
    mAwId[3:0] = 4'd3;
    #1;
    chk("R9 read granted", 64'(mArReady), 64'h2);
    chk("R9 write granted", 64'(mAwReady), 64'h1);
    chk("R9 write id", 64'(sAwId[5:0]), 64'({2'd0, 4'd3}));
    chk("R9 read id", 64'(sArId[5:0]), 64'({2'd1, 4'd7}));
  endtask

  task automatic tResponse();
    doReset();
    sRValid = 4'b0100;
    sRId[2*6 +: 6] = {2'd3, 4'd9};
    sRData[2*32 +: 32] = 32'hCAFE0123;
    #1;
    chk("R10 read valid routed", 64'(mRValid), 64'h8);
    chk("R10 id stripped", 64'(mRId[3*4 +: 4]), 64'h9);
    chk("R10 data routed", 64'(mRData[3*32 +: 32]), 64'hCAFE0123);
    chk("R10 ready back", 64'(sRReady), 64'h4);
    mRReady[3] = 1'b0;
    #1 chk("R10 ready follows master", 64'(sRReady), 64'h0);
    sBValid = 4'b0010;
    sBId[1*6 +: 6] = {2'd0, 4'd6};
    mBReady = 4'b1110;
    #1;
    chk("R10 write resp routed", 64'(mBValid), 64'h1);
    chk("R10 write resp id", 64'(mBId[3:0]), 64'h6);
    chk("R10 write resp held", 64'(sBReady), 64'h0);
    mBReady = 4'hF;
    #1 chk("R10 write resp ready", 64'(sBReady), 64'h2);
  endtask

  task automatic tCollide();
    doReset();
    sRValid = 4'b1010;
    sRId[1*6 +: 6] = {2'd2, 4'd1};
    sRId[3*6 +: 6] = {2'd2, 4'd3};
    sRData[1*32 +: 32] = 32'h1111AAAA;
    sRData[3*32 +: 32] = 32'h3333BBBB;
    #1;
    chk("R11 single master valid", 64'(mRValid), 64'h4);
    chk("R11 lowest port data", 64'(mRData[2*32 +: 32]), 64'h1111AAAA);
    chk("R11 lowest port id", 64'(mRId[2*4 +: 4]), 64'h1);
    chk("R11 only lowest ready", 64'(sRReady), 64'h2);
  endtask

  initial begin
    tReset();
    tDecode();
    tStall();
    tBudget();
    tZeroCount();
    tRoundRobin();
    tPriority();
    tCrossPort();
    tRelease();
    tIndep();
    tResponse();
    tCollide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule